// File: doc/BRIEF.md
# SPI Flash Chunked Read Sequencer

This block copies a region of a serial NOR flash into on-chip memory through a byte-wide write port. Software, or a boot controller, gives it a flash start address, a destination address and a byte count, then pulses start. The block splits the region into bursts. It opens each burst with the plain read command (0x03) and a 24-bit address. It clocks the data in over SPI mode 0 and writes each received data byte to consecutive destination addresses.

The burst size is capped so that the four header bytes and the data of one burst together fit a 64-byte receive buffer. Between bursts, chip select is held high for a programmable number of clock cycles to meet the flash deselect time. The serial clock is derived from the system clock by an even divider. The defaults give 6 MHz SCK and a 1 µs gap from a 24 MHz clock.

Top module: `spi_flash_chunk_reader`

## Requirements
- R1: Each burst starts with chip select falling. MOSI then carries 0x03 followed by the flash address, most significant byte first, MSB first within each byte. MOSI changes only while SCK is low, MISO is sampled on the SCK rising edge, and SCK is low whenever chip select is high.
- R2: Each burst carries min(remaining, CHUNK_MAX) data bytes, with CHUNK_MAX defaulting to 60. Chip select stays low for exactly 8*(4+n) SCK rising edges, where n is the burst's data byte count, so the last burst is sized to the exact remainder.
- R3: The four bytes received during the header are discarded. Data byte k of the job is written with wr_data_o equal to the flash byte at address start+k, and wr_addr_o equal to dst+k, in ascending order.
- R4: After each burst, the flash address, the destination pointer and the remaining count all move by that burst's length. Addresses wrap modulo 2^24 for flash and 2^DST_W for the destination.
- R5: Between two bursts of one job, chip select stays high for at least GAP_CYC clock cycles.
- R6: SCK stays high for exactly CLK_DIV/2 clock cycles per bit.
- R7: A start with a length of zero raises done_o in the next cycle. busy_o stays low, no write occurs, and chip select never falls.
- R8: For a nonzero length, busy_o is high from the cycle after start until the cycle of the final write, inclusive. done_o pulses for one cycle in the following cycle, with busy_o low. Every write occurs while busy_o is high.
- R9: start_i and the address and length inputs are ignored while busy_o is high. Changing them mid-job leaves the job's writes and headers unchanged.
- R10: A start presented in the cycle that done_o is high is accepted and begins a new job.
- R11: After reset, chip select is high, SCK is low, and busy_o, done_o and wr_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a job (sampled while idle) |
| flash_addr_i | input | 24 | Flash start address |
| dst_addr_i | input | DST_W | Destination start address |
| len_i | input | LEN_W | Number of bytes to copy |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | DST_W | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to flash |
| miso_i | input | 1 | SPI data from flash |
| cs_no | output | 1 | SPI chip select, active low |

## Verification
Completion of one job and acceptance of the next can fall in the same cycle: the idle state both emits the done pulse and samples start. The bench provokes this by driving start during the very cycle it observes done_o high. It judges the result by busy_o in the next cycle and by the full header, gap and write checks of the second job. A second coincidence is the closing write of a burst landing in the same cycle as chip select rising and the pointers advancing. The length sweep across multiples of the burst size exercises this, and it is judged by the next burst's header address.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned FADDR_W   = 24;
  localparam logic [7:0]  CMD_READ  = 8'h03;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (HALF <= 1) begin : g_direct
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni;
      assign tick_o   = en_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              cnt_q <= '0;
        else if (!en_i || cnt_q == CW'(HALF - 1)) cnt_q <= '0;
        else                                      cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = en_i && (cnt_q == CW'(HALF - 1));
    end
  endgenerate
endmodule

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter #(
  parameter int unsigned HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic       busy_q, sck_q, done_q, tick;
  logic [7:0] tx_q, rx_q;
  logic [2:0] bit_q;

  spi_rd_tick #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          bit_q  <= '0;
          sck_q  <= 1'b0;
        end
      end else if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  p_sck_low_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  p_sck_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick) |=> $stable(sck_q));
  p_go_when_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
endmodule

// File: rtl/spi_flash_chunk_reader.sv
module spi_flash_chunk_reader
  import spi_rd_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned DST_W     = 32,
  parameter int unsigned CHUNK_MAX = 60,
  parameter int unsigned CLK_DIV   = 4,
  parameter int unsigned GAP_CYC   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [23:0]        flash_addr_i,
  input  logic [DST_W-1:0]   dst_addr_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               wr_en_o,
  output logic [DST_W-1:0]   wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_no
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CH_W  = $clog2(CHUNK_MAX + 1);
  localparam int unsigned BURST = CHUNK_MAX + HDR_BYTES;
  localparam int unsigned IDX_W = $clog2(BURST);
  localparam int unsigned GW    = $clog2(GAP_CYC) + 1;

  function automatic logic [CH_W-1:0] clip(input logic [LEN_W-1:0] r);
    if (r > LEN_W'(CHUNK_MAX)) return CH_W'(CHUNK_MAX);
    return CH_W'(r);
  endfunction

  seq_state_e         state_q;
  logic [23:0]        flash_q;
  logic [DST_W-1:0]   dst_q, wr_addr_q;
  logic [LEN_W-1:0]   remain_q;
  logic [CH_W-1:0]    chunk_q;
  logic [IDX_W-1:0]   byte_q, last_idx;
  logic [GW-1:0]      gap_q;
  logic               cs_q, sh_go, done_q, wr_en_q;
  logic [7:0]         tx_byte, sh_rx, wr_data_q;
  logic               sh_done;

  assign last_idx = IDX_W'(HDR_BYTES - 1) + IDX_W'(chunk_q);

  always_comb begin
    tx_byte = 8'h00;
    if (byte_q == IDX_W'(0))      tx_byte = CMD_READ;
    else if (byte_q == IDX_W'(1)) tx_byte = flash_q[23:16];
    else if (byte_q == IDX_W'(2)) tx_byte = flash_q[15:8];
    else if (byte_q == IDX_W'(3)) tx_byte = flash_q[7:0];
  end

  spi_rd_shifter #(.HALF(HALF)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (sh_go),
    .tx_i   (tx_byte),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .done_o (sh_done),
    .rx_o   (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      flash_q   <= '0;
      dst_q     <= '0;
      remain_q  <= '0;
      chunk_q   <= '0;
      byte_q    <= '0;
      gap_q     <= '0;
      cs_q      <= 1'b1;
      sh_go     <= 1'b0;
      done_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      sh_go   <= 1'b0;
      done_q  <= 1'b0;
      wr_en_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              flash_q  <= flash_addr_i;
              dst_q    <= dst_addr_i;
              remain_q <= len_i;
              chunk_q  <= clip(len_i);
              byte_q   <= '0;
              cs_q     <= 1'b0;
              sh_go    <= 1'b1;
              state_q  <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (sh_done) begin
            if (byte_q >= IDX_W'(HDR_BYTES)) begin
              wr_en_q   <= 1'b1;
              wr_addr_q <= dst_q + DST_W'(byte_q - IDX_W'(HDR_BYTES));
              wr_data_q <= sh_rx;
            end
            if (byte_q == last_idx) begin
              cs_q     <= 1'b1;
              flash_q  <= flash_q + 24'(chunk_q);
              dst_q    <= dst_q + DST_W'(chunk_q);
              remain_q <= remain_q - LEN_W'(chunk_q);
              gap_q    <= '0;
              state_q  <= (remain_q == LEN_W'(chunk_q)) ? ST_FIN : ST_GAP;
            end else begin
              byte_q <= byte_q + 1'b1;
              sh_go  <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) begin
            chunk_q <= clip(remain_q);
            byte_q  <= '0;
            cs_q    <= 1'b0;
            sh_go   <= 1'b1;
            state_q <= ST_XFER;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign cs_no     = cs_q;

  p_cs_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (cs_q && !sck_o));
  p_sck_low_deselect_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !sck_o);
  p_wr_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> busy_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_chunk_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER) |-> (chunk_q != '0 && chunk_q <= CH_W'(CHUNK_MAX)));
  p_gap_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> cs_q);
  p_remain_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && sh_done && byte_q == last_idx)
      |=> (remain_q == $past(remain_q) - LEN_W'($past(chunk_q))));
endmodule

// File: tb/sim_spi_flash_chunk_reader.sv
module sim_spi_flash_chunk_reader;
  localparam int unsigned LW = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned CM = 8;
  localparam int unsigned CD = 2;
  localparam int unsigned GC = 5;
  localparam int unsigned HB = CD / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [23:0]   faddr = '0;
  logic [DW-1:0] daddr = '0;
  logic [LW-1:0] len = '0;
  logic          busy, done, wr_en, sck, mosi, cs_n;
  logic          miso = 1'b0;
  logic [DW-1:0] wr_addr;
  logic [7:0]    wr_data;

  always #4 clk = ~clk;

  spi_flash_chunk_reader #(
    .LEN_W(LW), .DST_W(DW), .CHUNK_MAX(CM), .CLK_DIV(CD), .GAP_CYC(GC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .flash_addr_i(faddr),
    .dst_addr_i(daddr), .len_i(len), .busy_o(busy), .done_o(done),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  logic          prev_cs = 1'b1, prev_sck = 1'b0;
  logic [31:0]   hdr = '0;
  logic [23:0]   e_faddr = '0, e_ca = '0;
  logic [DW-1:0] e_dst = '0;
  logic [7:0]    mb;
  int bcnt = 0, hi_cnt = 0, e_len = 0, e_rem = 0, e_wcnt = 0, gap_cnt = 0, cyc = 0;
  int k, b, n;
  bit in_gap = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        chk(e_rem > 0, "R7 burst only when data remains", e_rem, 1);
        if (in_gap) chk(gap_cnt >= GC, "R5 deselect gap", gap_cnt, GC);
        in_gap = 1'b0;
        bcnt = 0;
        hdr = '0;
      end
      if (cs_n && sck) chk(1'b0, "R1 sck high while deselected", sck, 0);
      if (!cs_n && !prev_sck && sck) begin
        if (bcnt < 32) hdr = {hdr[30:0], mosi};
        bcnt++;
        hi_cnt = 0;
      end
      if (sck) hi_cnt++;
      if (prev_sck && !sck) begin
        chk(hi_cnt == HB, "R6 sck high time", hi_cnt, HB);
        if (bcnt >= 32) begin
          k = (bcnt - 32) / 8;
          b = 7 - ((bcnt - 32) % 8);
          mb = fmem(hdr[23:0] + 24'(k));
          miso = mb[b];
        end
      end
      if (!prev_cs && cs_n) begin
        n = (e_rem > CM) ? CM : e_rem;
        chk(hdr[31:24] == 8'h03, "R1 command byte", hdr[31:24], 8'h03);
        chk(hdr[23:0] == e_ca, "R4 burst address", hdr[23:0], e_ca);
        chk(bcnt == 8 * (4 + n), "R2 burst length", bcnt, 8 * (4 + n));
        e_ca = e_ca + 24'(n);
        e_rem = e_rem - n;
        in_gap = (e_rem > 0);
        gap_cnt = 1;
      end else if (cs_n && in_gap) begin
        gap_cnt++;
      end
      if (wr_en) begin
        chk(busy, "R8 write while busy", busy, 1);
        chk(e_wcnt < e_len, "R3 write count", e_wcnt, e_len);
        chk(wr_addr == e_dst + DW'(e_wcnt), "R3 write address", wr_addr, e_dst + DW'(e_wcnt));
        chk(wr_data == fmem(e_faddr + 24'(e_wcnt)), "R3 write data", wr_data,
            fmem(e_faddr + 24'(e_wcnt)));
        e_wcnt++;
      end
    end
    prev_cs = cs_n;
    prev_sck = sck;
    if (cyc == 190000) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic launch(input logic [23:0] fa, input logic [DW-1:0] da, input int ln);
    e_faddr = fa;
    e_ca = fa;
    e_dst = da;
    e_len = ln;
    e_rem = ln;
    e_wcnt = 0;
    in_gap = 1'b0;
    start = 1'b1;
    faddr = fa;
    daddr = da;
    len = LW'(ln);
    @(negedge clk);
    start = 1'b0;
    faddr = ~fa;
    daddr = ~da;
    len = ~LW'(ln);
  endtask

  task automatic wait_done(input int ln);
    int bad = 0;
    int lim = 0;
    if (ln == 0) begin
      chk(done && !busy, "R7 immediate done", {done, busy}, 2'b10);
      repeat (3) begin
        @(negedge clk);
        chk(cs_n && !busy && e_wcnt == 0, "R7 no activity", {cs_n, busy}, 2'b10);
      end
    end else begin
      chk(busy && !done, "R8 busy after start", {busy, done}, 2'b10);
      while (!done && lim < 20000) begin
        if (!busy) bad++;
        @(negedge clk);
        lim++;
      end
      chk(lim < 20000, "R8 job completes", lim, 20000);
      chk(bad == 0, "R8 busy held", bad, 0);
      chk(!busy, "R8 busy low at done", busy, 0);
      chk(e_wcnt == ln, "R8 all bytes written before done", e_wcnt, ln);
      chk(e_rem == 0, "R2 all bursts issued", e_rem, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sck && !busy && !done && !wr_en, "R11 reset state",
        {cs_n, sck, busy, done, wr_en}, 5'b10000);

    for (int l = 0; l <= 3 * CM + 2; l++) begin
      launch(24'(l * 24'h001357 + 24'h00F0F0), DW'(16'h0400 + l * 40), l);
      wait_done(l);
      repeat (2) @(negedge clk);
    end

    // R4 wrap of both address spaces
    launch(24'hFFFFFA, 16'hFFF9, 13);
    wait_done(13);
    repeat (2) @(negedge clk);

    // R9 restart attempt mid-job
    launch(24'h123456, 16'h2000, 20);
    repeat (30) @(negedge clk);
    start = 1'b1;
    faddr = 24'hABCDEF;
    daddr = 16'h7777;
    len = 8'd3;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 busy after ignored start", busy, 1);
    wait_done(20);
    chk(e_wcnt == 20, "R9 job unchanged by start", e_wcnt, 20);
    repeat (2) @(negedge clk);

    // R10 start in the done cycle
    launch(24'h0A0B0C, 16'h3000, 9);
    wait_done(9);
    launch(24'h505050, 16'h3100, 5);
    chk(busy, "R10 start accepted in done cycle", busy, 1);
    wait_done(5);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule